// File: doc/BRIEF.md
# Bitwise Ternary Logic Unit

This unit takes three operand vectors and evaluates any Boolean function of three inputs across them, one bit position at a time. The function comes from an 8-bit truth-table code rather than from a fixed opcode. For each bit position i, the operand bits `op_a[i]`, `op_b[i]` and `op_c[i]` form a 3-bit index, and that index selects one bit of the code. The selected bit becomes `out_result[i]`. Every position uses the same code, and no position depends on any other.

The result is captured by a single register stage. A valid strobe asserted with the operands produces a result and a raised `out_valid` exactly one clock later. When the strobe is low, the result register keeps its last value and `out_valid` falls.

The output stage is a two-state machine:
- `OUT_EMPTY` means no result was accepted on the last edge.
- `OUT_FULL` means a result was accepted on the last edge.

It has four transitions:
- EMPTY to FULL on `in_valid`.
- FULL to FULL on `in_valid`.
- FULL to EMPTY without it.
- EMPTY to EMPTY without it.

Reset forces `OUT_EMPTY` and clears the result.

Top module: `bitwise_tern_unit`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, the next edge gives `out_valid` = 0 and `out_result` = 0.
- R2: For each bit i, the result bit is `func_code[{op_a[i],op_b[i],op_c[i]}]`, with `op_a` as the index MSB. Index 7 is f(1,1,1) and index 0 is f(0,0,0). The result appears on the edge after `in_valid` is sampled high.
- R3: `out_valid` is 1 in exactly the cycle after an edge where `in_valid` was 1, and 0 after an edge where it was 0.
- R4: When `in_valid` is sampled low, `out_result` keeps its previous value, whatever the operands and code are.
- R5: Code 0xB0 computes a AND (NOT b OR c). Per bit, (a,b,c) = 100, 101 and 111 give 1 and all other combinations give 0.
- R6: Code 0xF0 reproduces `op_a`, code 0xCC reproduces `op_b`, and code 0xAA reproduces `op_c`.
- R7: Code 0x00 gives all zeros and code 0xFF gives all ones, for any operands.
- R8: All WIDTH positions use the same code independently. When operands 0xF0.., 0xCC.., 0xAA.. present all eight index values across each byte, every byte of the result equals the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_a | input | WIDTH | First operand, index MSB |
| op_b | input | WIDTH | Second operand, index middle bit |
| op_c | input | WIDTH | Third operand, index LSB |
| func_code | input | 8 | Truth table of the three-input function |
| out_valid | output | 1 | Result accepted on the last edge |
| out_result | output | WIDTH | Registered bitwise result |

## Verification
The main sweep runs all 256 codes against the operand pattern a=0xF0.., b=0xCC.., c=0xAA... That pattern places every index value in each byte, so a wrong index order, a swapped operand or a lane tie shows as a result byte that differs from the code. Random codes with random operands are then checked against a per-bit model computed by shifting the code. This separates per-lane faults that the fixed pattern repeats identically. Directed codes 0xB0, 0xF0, 0xCC, 0xAA, 0x00 and 0xFF confirm the named functions. Strobe-low cycles with changed inputs show that the result holds and the valid flag drops.

// File: rtl/tern_pkg.sv
package tern_pkg;
    localparam int CODE_W = 8;
    localparam int SEL_W  = $clog2(CODE_W);

    typedef logic [CODE_W-1:0] func_code_t;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/tern_bit_sel.sv
module tern_bit_sel
    import tern_pkg::*;
(
    input  func_code_t code,
    input  logic       bit_a,
    input  logic       bit_b,
    input  logic       bit_c,
    output logic       bit_y
);
    logic [SEL_W-1:0] sel;

    always_comb begin
        sel   = {bit_a, bit_b, bit_c};
        bit_y = code[sel];
    end
endmodule

// File: rtl/tern_lane_array.sv
module tern_lane_array
    import tern_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  func_code_t       code,
    input  logic [WIDTH-1:0] vec_a,
    input  logic [WIDTH-1:0] vec_b,
    input  logic [WIDTH-1:0] vec_c,
    output logic [WIDTH-1:0] vec_y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        tern_bit_sel u_sel (
            .code  (code),
            .bit_a (vec_a[i]),
            .bit_b (vec_b[i]),
            .bit_c (vec_c[i]),
            .bit_y (vec_y[i])
        );
    end
endmodule

// File: rtl/tern_out_stage.sv
module tern_out_stage
    import tern_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] lane_bits,
    output logic             valid_q,
    output logic [WIDTH-1:0] result_q
);
    out_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: state_d = load ? OUT_FULL : OUT_EMPTY;
            OUT_FULL:  state_d = load ? OUT_FULL : OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_EMPTY;
        else     state_q <= state_d;
    end

    // Result register
    always_ff @(posedge clk) begin
        if (rst)       result_q <= '0;
        else if (load) result_q <= lane_bits;
    end

    assign valid_q = (state_q == OUT_FULL);

    // R1: reset empties the stage
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!valid_q && result_q == '0));

    // R3: valid follows the strobe by one edge
    p_valid_follow_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> valid_q);
    p_valid_drop_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> !valid_q);

    // R2: captured value is the lane output of the previous cycle
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> result_q == $past(lane_bits));

    // R4: no strobe, no change
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(result_q));
endmodule

// File: rtl/bitwise_tern_unit.sv
module bitwise_tern_unit
    import tern_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] op_c,
    input  logic [7:0]       func_code,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_result
);
    logic [WIDTH-1:0] lane_bits;

    tern_lane_array #(.WIDTH(WIDTH)) u_lanes (
        .code  (func_code),
        .vec_a (op_a),
        .vec_b (op_b),
        .vec_c (op_c),
        .vec_y (lane_bits)
    );

    tern_out_stage #(.WIDTH(WIDTH)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .load      (in_valid),
        .lane_bits (lane_bits),
        .valid_q   (out_valid),
        .result_q  (out_result)
    );

    // R5: the 0xB0 code behaves as a & (~b | c)
    p_code_b0_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_code == 8'hB0) |=>
            out_result == ($past(op_a) & (~$past(op_b) | $past(op_c))));

    // R6: identity codes pass one operand through
    p_ident_a_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_code == 8'hF0) |=> out_result == $past(op_a));
    p_ident_b_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_code == 8'hCC) |=> out_result == $past(op_b));
    p_ident_c_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_code == 8'hAA) |=> out_result == $past(op_c));

    // R7: constant codes
    p_const_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_code == 8'h00) |=> out_result == '0);
    p_const_one_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_code == 8'hFF) |=> out_result == '1);
endmodule

// File: tb/tb_bitwise_tern_unit.sv
module tb_bitwise_tern_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
    logic [7:0]   func_code = '0;
    logic         out_valid;
    logic [W-1:0] out_result;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    bitwise_tern_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .func_code(func_code),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [W-1:0] model(input logic [7:0] code,
        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int idx;
            idx  = 4 * int'(a[i]) + 2 * int'(b[i]) + int'(c[i]);
            r[i] = (code >> idx) & 8'd1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on negedge, sample one edge later at the next negedge
    task automatic apply(input string req, input logic [7:0] code,
        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
        input logic [W-1:0] exp);
        @(negedge clk);
        in_valid = 1'b1; func_code = code; op_a = a; op_b = b; op_c = c;
        @(negedge clk);
        check("R3 valid", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, 1'b1});
        check(req, out_result, exp);
    endtask

    initial begin
        logic [W-1:0] ra, rb, rc, held;
        logic [7:0]   rcode;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {{(W-1){1'b0}}, out_valid}, '0);
        check("R1 result", out_result, '0);
        rst = 1'b0;

        // R8 / R2: all codes against the all-index pattern
        for (int k = 0; k < 256; k++)
            apply("R8 sweep", 8'(k), {4{8'hF0}}, {4{8'hCC}}, {4{8'hAA}}, {4{8'(k)}});

        // R5 directed
        apply("R5 b0", 8'hB0, {4{8'hF0}}, {4{8'hCC}}, {4{8'hAA}}, {4{8'hB0}});
        ra = 32'h1234_F00D; rb = 32'h0FF0_5A5A; rc = 32'hC3C3_3C3C;
        apply("R5 b0 expr", 8'hB0, ra, rb, rc, ra & (~rb | rc));

        // R6 identities
        apply("R6 a", 8'hF0, ra, rb, rc, ra);
        apply("R6 b", 8'hCC, ra, rb, rc, rb);
        apply("R6 c", 8'hAA, ra, rb, rc, rc);

        // R7 constants
        apply("R7 zero", 8'h00, ra, rb, rc, '0);
        apply("R7 ones", 8'hFF, ra, rb, rc, '1);

        // R4 hold: strobe low, inputs changed
        held = out_result;
        @(negedge clk);
        in_valid = 1'b0; func_code = 8'h3C; op_a = ~ra; op_b = ~rb; op_c = ~rc;
        @(negedge clk);
        check("R3 drop", {{(W-1){1'b0}}, out_valid}, '0);
        check("R4 hold", out_result, held);
        @(negedge clk);
        check("R4 hold2", out_result, held);

        // R2 random codes and operands
        for (int k = 0; k < 300; k++) begin
            rcode = 8'($urandom);
            ra = $urandom; rb = $urandom; rc = $urandom;
            apply("R2 random", rcode, ra, rb, rc, model(rcode, ra, rb, rc));
        end

        // R1 reset mid-stream
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R1 re-reset", out_result, '0);
        check("R1 re-valid", {{(W-1){1'b0}}, out_valid}, '0);
        rst = 1'b0;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule